// File: doc/BRIEF.md
# Serial Audio Sample Transmitter

This block takes a pair of 24-bit two's complement audio samples (left and right) and sends them as a three-wire serial stream: a bit clock, a channel clock running at the sample rate fs, and a data line. Alongside these it has a frame-enable line. The block runs from a single clock `clk_i`, which is the master clock. That clock is 256·fs in normal speed and 128·fs in double speed.

In master mode the block generates the bit clock, the channel clock and the frame-enable line itself. In slave mode it takes all three from outside. These inputs must be synchronous to `clk_i`, and the bit clock may be at most `clk_i`/2. Two data formats are supported. In left-justified format the MSB is on the line with the channel-clock edge. In I2S format the MSB comes one bit clock later. In slave left-justified mode the frame-enable input gates the shifting. In I2S mode that input has no effect.

The surrounding logic writes a sample pair with a one-cycle strobe. The pair is moved into the output register at the start of each left slot.

Top module: `sap_tx`

## Requirements
- R1: While `rst_ni` is low, `sclk_o`, `lrck_o`, `fsync_o` and `sdata_o` are all 0. Reset is asynchronous.
- R2: In master mode `sclk_o` toggles on every `clk_i` cycle (clk/2), at both speeds.
- R3: In master mode each channel slot lasts 64 bit clocks (`dfs_i`=0) or 32 bit clocks (`dfs_i`=1), so the frame is 256 or 128 clk cycles. `lrck_o` changes only in the cycle where `sclk_o` falls. The first slot after reset is the left slot. The left slot has `lrck_o`=1 in left-justified format and `lrck_o`=0 in I2S format (`i2s_i`=1).
- R4: In master mode `fsync_o` runs at 2·fs. It is 1 for the first half of each slot and 0 for the second half, and it changes together with a `sclk_o` fall.
- R5: Words are sent MSB first. In master mode `sdata_o` changes only in the cycle where `sclk_o` falls.
- R6: Left-justified format: bit 23 of the word is sent on the first counted bit-clock fall of a slot, and bits 22 down to 0 follow on the next counted falls. After that, `sdata_o` is 0 until the slot ends.
- R7: I2S format: the first bit-clock fall of a slot sends 0. The next 24 falls send bits 23 down to 0. The rest of the slot is 0.
- R8: Slave left-justified mode: a bit-clock fall with `fsync_i`=0 sends 0 and does not advance the bit position.
- R9: Slave I2S mode: `fsync_i` is ignored, and every fall advances the bit position.
- R10: `sample_valid_i` captures `left_i` and `right_i` into a holding pair. The pair moves to the output register at the first fall of each left slot, so the left and right words of one frame always come from the same capture.
- R11: In slave mode (`master_i`=0), `sclk_o`, `lrck_o` and `fsync_o` stay 0. `sdata_o` updates one `clk_i` cycle after `sclk_i` is seen falling, using the `lrck_i` and `fsync_i` values present with that fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (256·fs normal, 128·fs double speed) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: generate clocks, 0: follow external clocks |
| dfs_i | input | 1 | 1: double speed (32-bit slots in master mode) |
| i2s_i | input | 1 | 1: I2S format, 0: left-justified |
| sample_valid_i | input | 1 | Strobe capturing both samples |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| sclk_i | input | 1 | External bit clock (slave mode) |
| lrck_i | input | 1 | External channel clock (slave mode) |
| fsync_i | input | 1 | External frame enable (slave mode) |
| sclk_o | output | 1 | Generated bit clock |
| lrck_o | output | 1 | Generated channel clock |
| fsync_o | output | 1 | Generated frame enable at 2·fs |
| sdata_o | output | 1 | Serial data |

## Verification
In master mode the bit clock, channel clock, frame-enable line and data all come from registers that update on the same `clk_i` edge. Every master check therefore samples at the falling `clk_i` edge right after `sclk_o` is seen going low, and tests all outputs there. In slave mode the bench drops `sclk_i` on a falling `clk_i` edge, and the data is due at the next rising edge, so the check samples one `clk_i` cycle later. Reset forces the outputs low at once, so reset checks sample half a cycle after `rst_ni` falls.

// File: rtl/sap_pkg.sv
package sap_pkg;
  typedef enum logic {CH_RIGHT = 1'b0, CH_LEFT = 1'b1} chan_e;

  // one bit-clock fall plus the framing levels valid with it
  typedef struct packed {
    logic fall;
    logic lrck;
    logic fsync;
  } sbus_t;
endpackage

// File: rtl/sap_master_gen.sv
module sap_master_gen
  import sap_pkg::*;
#(
  parameter int SLOT_NS = 64,
  parameter int POS_W   = $clog2(SLOT_NS) + 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  dfs_i,
  input  logic  i2s_i,
  output logic  sclk_o,
  output logic  lrck_o,
  output logic  fsync_o,
  output sbus_t ev_o
);
  localparam logic [POS_W-1:0] SLOT_N = POS_W'(SLOT_NS);
  localparam logic [POS_W-1:0] SLOT_D = POS_W'(SLOT_NS / 2);

  logic             sclk_q, lrck_q, fsync_q;
  logic [POS_W-1:0] pos_q, pos_nx, slot_len, frame_last, spos;
  logic             left_nx, lrck_nx, fsync_nx;

  always_comb begin
    slot_len   = dfs_i ? SLOT_D : SLOT_N;
    frame_last = (slot_len << 1) - 1'b1;
    pos_nx     = (pos_q >= frame_last) ? '0 : pos_q + 1'b1;
    left_nx    = pos_nx < slot_len;
    spos       = left_nx ? pos_nx : pos_nx - slot_len;
    fsync_nx   = spos < (slot_len >> 1);
    lrck_nx    = left_nx ^ i2s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      lrck_q  <= 1'b0;
      fsync_q <= 1'b0;
      pos_q   <= '1;
    end else if (!en_i) begin
      sclk_q  <= 1'b0;
      lrck_q  <= 1'b0;
      fsync_q <= 1'b0;
      pos_q   <= '1;
    end else begin
      sclk_q <= ~sclk_q;
      if (sclk_q) begin
        pos_q   <= pos_nx;
        lrck_q  <= lrck_nx;
        fsync_q <= fsync_nx;
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign lrck_o   = lrck_q;
  assign fsync_o  = fsync_q;
  assign ev_o.fall  = en_i & sclk_q;
  assign ev_o.lrck  = lrck_nx;
  assign ev_o.fsync = fsync_nx;
endmodule

// File: rtl/sap_slave_sync.sv
module sap_slave_sync
  import sap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  sclk_i,
  input  logic  lrck_i,
  input  logic  fsync_i,
  output sbus_t ev_o
);
  logic sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sclk_d <= 1'b0;
    else if (!en_i) sclk_d <= 1'b0;
    else            sclk_d <= sclk_i;
  end

  assign ev_o.fall  = en_i & sclk_d & ~sclk_i;
  assign ev_o.lrck  = lrck_i;
  assign ev_o.fsync = fsync_i;
endmodule

// File: rtl/sap_serializer.sv
module sap_serializer
  import sap_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int PTR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sbus_t             ev_i,
  input  logic              i2s_i,
  input  logic              gate_i,
  input  logic              sample_valid_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic              sdata_o
);
  localparam logic [PTR_W-1:0] PTR_MAX  = '1;
  localparam logic [PTR_W-1:0] WORD_END = PTR_W'(WORD_W);

  logic [WORD_W-1:0] hold_l_q, hold_r_q, act_l_q, act_r_q, word, shifted;
  logic [PTR_W-1:0]  ptr_q, ptr_base, ptr_nx, idx, lead;
  chan_e             ch_q, ch_now;
  logic              start, qual, in_word, bit_val, sdata_q;

  always_comb begin
    ch_now   = (ev_i.lrck ^ i2s_i) ? CH_LEFT : CH_RIGHT;
    start    = ch_now != ch_q;
    ptr_base = start ? '0 : ptr_q;
    qual     = ~gate_i | ev_i.fsync;
    lead     = {{(PTR_W-1){1'b0}}, i2s_i};
    idx      = ptr_base - lead;
    in_word  = (ptr_base >= lead) && (idx < WORD_END);
    if (ch_now == CH_LEFT) word = start ? hold_l_q : act_l_q;
    else                   word = act_r_q;
    shifted  = word << idx;
    bit_val  = qual & in_word & shifted[WORD_W-1];
    if (!qual)                  ptr_nx = ptr_base;
    else if (ptr_base == PTR_MAX) ptr_nx = ptr_base;
    else                        ptr_nx = ptr_base + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      act_l_q  <= '0;
      act_r_q  <= '0;
      ptr_q    <= '0;
      ch_q     <= CH_RIGHT;
      sdata_q  <= 1'b0;
    end else begin
      if (sample_valid_i) begin
        hold_l_q <= left_i;
        hold_r_q <= right_i;
      end
      if (ev_i.fall) begin
        ch_q    <= ch_now;
        ptr_q   <= ptr_nx;
        sdata_q <= bit_val;
        if (start && ch_now == CH_LEFT) begin
          act_l_q <= hold_l_q;
          act_r_q <= hold_r_q;
        end
      end
    end
  end

  assign sdata_o = sdata_q;
endmodule

// File: rtl/sap_tx.sv
module sap_tx
  import sap_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int SLOT_NS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              dfs_i,
  input  logic              i2s_i,
  input  logic              sample_valid_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              sclk_i,
  input  logic              lrck_i,
  input  logic              fsync_i,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic              fsync_o,
  output logic              sdata_o
);
  localparam int POS_W = $clog2(SLOT_NS) + 2;
  localparam int PTR_W = $clog2(SLOT_NS) + 2;

  sbus_t ev_m, ev_s, ev;
  logic  gate;

  sap_master_gen #(.SLOT_NS(SLOT_NS), .POS_W(POS_W)) u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (master_i),
    .dfs_i   (dfs_i),
    .i2s_i   (i2s_i),
    .sclk_o  (sclk_o),
    .lrck_o  (lrck_o),
    .fsync_o (fsync_o),
    .ev_o    (ev_m)
  );

  sap_slave_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (~master_i),
    .sclk_i  (sclk_i),
    .lrck_i  (lrck_i),
    .fsync_i (fsync_i),
    .ev_o    (ev_s)
  );

  assign ev   = master_i ? ev_m : ev_s;
  assign gate = ~master_i & ~i2s_i;

  sap_serializer #(.WORD_W(WORD_W), .PTR_W(PTR_W)) u_ser (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ev_i           (ev),
    .i2s_i          (i2s_i),
    .gate_i         (gate),
    .sample_valid_i (sample_valid_i),
    .left_i         (left_i),
    .right_i        (right_i),
    .sdata_o        (sdata_o)
  );
endmodule

// File: rtl/sap_tx_chk.sv
module sap_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic i2s_i,
  input logic sclk_i,
  input logic fsync_i,
  input logic sclk_o,
  input logic lrck_o,
  input logic fsync_o,
  input logic sdata_o
);
  logic up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;
  end

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!sclk_o && !lrck_o && !fsync_o && !sdata_o));

  // R2
  sclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && master_i) |-> (sclk_o != $past(sclk_o)));

  // R3
  lrck_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && master_i && lrck_o != $past(lrck_o)) |-> ($past(sclk_o) && !sclk_o));

  // R4
  fsync_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && master_i && fsync_o != $past(fsync_o)) |-> ($past(sclk_o) && !sclk_o));

  // R5
  sdata_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && master_i && sdata_o != $past(sdata_o)) |-> ($past(sclk_o) && !sclk_o));

  // R8
  gated_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && !master_i && !i2s_i && $past(sclk_i) && !sclk_i && !fsync_i) |=> !sdata_o);

  // R11
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (!sclk_o && !lrck_o && !fsync_o));
endmodule

bind sap_tx sap_tx_chk u_chk (.*);

// File: tb/sap_tx_tb.sv
module sap_tx_tb;
  localparam int W = 24;
  localparam int SLOT_S = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, master = 1'b1, dfs = 1'b0, i2s = 1'b0, sv = 1'b0;
  logic [W-1:0] left = '0, right = '0;
  logic sclk_in = 1'b0, lrck_in = 1'b0, fsync_in = 1'b0;
  logic sclk_o, lrck_o, fsync_o, sdata_o;

  sap_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .dfs_i(dfs), .i2s_i(i2s),
    .sample_valid_i(sv), .left_i(left), .right_i(right),
    .sclk_i(sclk_in), .lrck_i(lrck_in), .fsync_i(fsync_in),
    .sclk_o(sclk_o), .lrck_o(lrck_o), .fsync_o(fsync_o), .sdata_o(sdata_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] hold_l, hold_r, act_l, act_r;
  int k_pat = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pat(input int k);
    case (k % 6)
      0: return 24'h800000;
      1: return 24'h7fffff;
      2: return 24'hffffff;
      3: return 24'h000001;
      default: return W'(k * 32'h00a5c3d1 + 32'h135);
    endcase
  endfunction

  function automatic logic exp_bit(input logic [W-1:0] w, input int idx);
    if (idx >= 0 && idx < W) return w[W-1-idx];
    return 1'b0;
  endfunction

  task automatic load_next();
    hold_l = pat(k_pat);
    hold_r = pat(k_pat + 3) ^ 24'h0f0f0f;
    k_pat++;
    left = hold_l;
    right = hold_r;
    sv = 1'b1;
  endtask

  // master-mode monitor
  bit mon_en = 0, seen = 0, first = 0, sv_own = 0;
  logic sc_prev, ch_prev;
  int pos, slot_len;

  always @(negedge clk) begin
    logic ch;
    logic [W-1:0] w;
    if (sv_own) begin sv = 1'b0; sv_own = 0; end
    if (mon_en) begin
      if (!seen) begin
        seen = 1;
      end else begin
        chk(sclk_o != sc_prev, "R2 sclk toggle", sclk_o, !sc_prev);
        if (sc_prev && !sclk_o) begin
          ch = lrck_o ^ i2s;
          if (first) chk(lrck_o == !i2s, "R3 first slot left", lrck_o, !i2s);
          if (ch != ch_prev) begin
            if (!first) chk(pos + 1 == slot_len, "R3 slot length", pos + 1, slot_len);
            pos = 0;
            if (ch) begin act_l = hold_l; act_r = hold_r; end
          end else pos++;
          first = 0;
          ch_prev = ch;
          chk(fsync_o == (pos < slot_len / 2), "R4 fsync", fsync_o, pos < slot_len / 2);
          w = ch ? act_l : act_r;
          chk(sdata_o == exp_bit(w, pos - int'(i2s)), i2s ? "R7 R5 R10 data" : "R6 R5 R10 data",
              sdata_o, exp_bit(w, pos - int'(i2s)));
          if (ch && pos == 8) begin load_next(); sv_own = 1; end
        end
      end
      sc_prev = sclk_o;
    end
  end

  task automatic check_reset_low();
    chk(!sclk_o && !lrck_o && !fsync_o && !sdata_o, "R1 outputs low in reset",
        {sclk_o, lrck_o, fsync_o, sdata_o}, 0);
  endtask

  task automatic run_master(input logic d, input logic f);
    rst_n = 1'b0;
    master = 1'b1; dfs = d; i2s = f;
    repeat (3) @(negedge clk);
    check_reset_low();
    slot_len = d ? 32 : 64;
    first = 1; seen = 0; ch_prev = 1'b0; pos = 0;
    load_next();
    rst_n = 1'b1;
    mon_en = 1;
    @(negedge clk);
    sv = 1'b0;
    repeat (4 * 4 * slot_len) @(negedge clk);
    mon_en = 0;
    rst_n = 1'b0;
    #1;
    check_reset_low();
  endtask

  task automatic run_slave(input logic f, input int frames);
    int ptr;
    logic chp, ch, fs, e;
    logic [W-1:0] w;
    rst_n = 1'b0;
    master = 1'b0; dfs = 1'b0; i2s = f;
    sclk_in = 1'b0; lrck_in = f; fsync_in = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_low();
    load_next();
    rst_n = 1'b1;
    @(negedge clk);
    sv = 1'b0;
    chp = 1'b0; ptr = 0;
    for (int fr = 0; fr < frames; fr++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < SLOT_S; p++) begin
          sclk_in = 1'b1;
          sv = 1'b0;
          @(negedge clk);
          @(negedge clk);
          ch = (s == 0);
          fs = f ? logic'((p % 3) != 0) : logic'(!(p == 3 || p == 4 || p == 15 || p >= 28));
          lrck_in = ch ^ f; fsync_in = fs; sclk_in = 1'b0;
          if (ch != chp) begin
            ptr = 0;
            if (ch) begin act_l = hold_l; act_r = hold_r; end
          end
          chp = ch;
          w = ch ? act_l : act_r;
          if (f) begin
            e = exp_bit(w, ptr - 1);
            ptr++;
          end else begin
            e = fs ? exp_bit(w, ptr) : 1'b0;
            if (fs) ptr++;
          end
          @(negedge clk);
          chk(sdata_o == e, f ? "R9 R7 R11 slave data" : "R8 R6 R11 slave data", sdata_o, e);
          chk(!sclk_o && !lrck_o && !fsync_o, "R11 outputs quiet", {sclk_o, lrck_o, fsync_o}, 0);
          if (ch && p == 8) load_next();
          @(negedge clk);
        end
      end
    end
    sv = 1'b0;
  endtask

  initial begin
    #1;
    check_reset_low();
    run_master(1'b0, 1'b0);
    run_master(1'b1, 1'b0);
    run_master(1'b0, 1'b1);
    run_master(1'b1, 1'b1);
    run_slave(1'b0, 3);
    run_slave(1'b1, 3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", n_chk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule